// File: doc/BRIEF.md
# UART Dual Address Match Filter

This block sits between a UART receive deframer and the receive data buffer and decides, character by character, whether a received character is written into the buffer. Each character arrives with its data bits and an address-mark bit; the mark is carried in the frame slot that a parity bit would otherwise use, for both 8-bit and 9-bit data formats, so the deframer hands it over as a separate bit. Two match values, each with its own enable, define which marked characters count as addresses for this receiver.

When at least one enable is set, a marked character is compared with every enabled match value and is a hit if any of them equals it. A hit opens the filter: the address character itself is forwarded with an address flag, and the unmarked data characters that follow are forwarded too. A marked character that misses closes the filter, and data is discarded until the next marked character. With both enables clear the filter is bypassed and every character is forwarded. An accept-state flag carries the open/closed decision between frames and is visible as a status pin.

Characters enter and leave on valid/ready streams. The output is a single register stage: a character is taken on a cycle where `in_valid` and `in_ready` are both high, and `in_ready` is high whenever the output stage is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output holds its data and flag unchanged and no new character is taken. Discarded characters are taken from the input in the normal way and produce no output beat.

Top module: `uart_addr_filter`

## Requirements
- R1: After reset `out_valid` is 0 and `match_state` is 0, so with filtering enabled no unmarked character is forwarded until a marked hit is seen.
- R2: With `en_a` and `en_b` both 0, every taken character is forwarded with `out_addr` = 0, whatever its mark bit.
- R3: With only `en_a` set, a marked character is a hit only if it equals `match_a`; equality with `match_b` alone does not count.
- R4: With only `en_b` set, a marked character is a hit only if it equals `match_b`; equality with `match_a` alone does not count.
- R5: With both enables set, a marked character is a hit if it equals either `match_a` or `match_b`.
- R6: A marked hit is forwarded with `out_addr` = 1 and sets `match_state` to 1.
- R7: While filtering is enabled, an unmarked character is forwarded with `out_addr` = 0 when `match_state` is 1 and is taken and discarded when it is 0.
- R8: While filtering is enabled, a marked miss is discarded and clears `match_state` to 0.
- R9: A character taken at a clock edge appears on the output at that same edge (one register stage); `in_ready` equals `!out_valid || out_ready`, and a stalled output holds its data and flag.
- R10: Characters taken while both enables are 0 leave `match_state` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received character is offered |
| in_ready | output | 1 | The filter can take a character this cycle |
| in_data | input | DATA_W | Received data bits |
| in_mark | input | 1 | Address-mark bit from the parity position |
| match_a | input | DATA_W | First match value |
| match_b | input | DATA_W | Second match value |
| en_a | input | 1 | Enable comparison against `match_a` |
| en_b | input | 1 | Enable comparison against `match_b` |
| out_valid | output | 1 | A character is offered to the receive buffer |
| out_ready | input | 1 | The receive buffer takes the character |
| out_data | output | DATA_W | Forwarded character |
| out_addr | output | 1 | Forwarded character is a matched address |
| match_state | output | 1 | Filter open (last marked character hit) |

## Verification
Every result of a character taken at one rising edge is due right after that edge: the output beat, its address flag and the new `match_state` all appear together, while `in_ready` follows `out_ready` within the same cycle. The bench therefore drives inputs shortly after the falling edge, lets its reference model step on the rising edge from the same inputs, and compares every output a few nanoseconds after the next falling edge, so each comparison sees the values produced by exactly one edge. Back-pressure phases toggle `out_ready` at random to exercise the stall-and-hold rule against the same model.

// File: rtl/uaf_pkg.sv
package uaf_pkg;
  // Per-character decision taken by the accept-state logic.
  typedef enum logic [1:0] {
    DEC_DROP = 2'd0,
    DEC_DATA = 2'd1,
    DEC_ADDR = 2'd2
  } uaf_dec_e;
endpackage

// File: rtl/uaf_addr_cmp.sv
module uaf_addr_cmp #(
  parameter int DATA_W    = 8,
  parameter int NUM_MATCH = 2
) (
  input  logic [NUM_MATCH-1:0][DATA_W-1:0] match_vals,
  input  logic [NUM_MATCH-1:0]             match_en,
  input  logic [DATA_W-1:0]                chr,
  output logic                             hit,
  output logic                             any_en
);
  logic [NUM_MATCH-1:0] hits;

  // One equality comparator per match value, gated by its own enable.
  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
    assign hits[i] = match_en[i] && (chr == match_vals[i]);
  end

  assign hit    = |hits;
  assign any_en = |match_en;
endmodule

// File: rtl/uaf_accept_state.sv
module uaf_accept_state
  import uaf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fire,
  input  logic     mark,
  input  logic     any_en,
  input  logic     hit,
  output uaf_dec_e dec,
  output logic     acc_q
);
  always_comb begin
    if (!any_en)   dec = DEC_DATA;
    else if (mark) dec = hit ? DEC_ADDR : DEC_DROP;
    else           dec = acc_q ? DEC_DATA : DEC_DROP;
  end

  // Only a marked character under active filtering moves the flag.
  always_ff @(posedge clk) begin
    if (!rst_n)                      acc_q <= 1'b0;
    else if (fire && any_en && mark) acc_q <= hit;
  end
endmodule

// File: rtl/uaf_out_stage.sv
module uaf_out_stage
  import uaf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              fire,
  input  uaf_dec_e          dec,
  input  logic [DATA_W-1:0] chr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_addr
);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (fire) begin
      out_valid <= (dec != DEC_DROP);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data <= '0;
      out_addr <= 1'b0;
    end else if (fire && dec != DEC_DROP) begin
      out_data <= chr;
      out_addr <= (dec == DEC_ADDR);
    end
  end
endmodule

// File: rtl/uart_addr_filter.sv
module uart_addr_filter
  import uaf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mark,
  input  logic [DATA_W-1:0] match_a,
  input  logic [DATA_W-1:0] match_b,
  input  logic              en_a,
  input  logic              en_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_addr,
  output logic              match_state
);
  localparam int NUM_MATCH = 2;

  logic [NUM_MATCH-1:0][DATA_W-1:0] match_vals;
  logic [NUM_MATCH-1:0]             match_en;
  logic     hit, any_en, fire;
  uaf_dec_e dec;

  assign match_vals = {match_b, match_a};
  assign match_en   = {en_b, en_a};

  uaf_addr_cmp #(.DATA_W(DATA_W), .NUM_MATCH(NUM_MATCH)) u_cmp (
    .match_vals (match_vals),
    .match_en   (match_en),
    .chr        (in_data),
    .hit        (hit),
    .any_en     (any_en)
  );

  uaf_accept_state u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .mark   (in_mark),
    .any_en (any_en),
    .hit    (hit),
    .dec    (dec),
    .acc_q  (match_state)
  );

  uaf_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .fire      (fire),
    .dec       (dec),
    .chr       (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_addr  (out_addr)
  );
endmodule

// File: rtl/uaf_checker.sv
module uaf_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              in_mark,
  input logic [DATA_W-1:0] match_a,
  input logic [DATA_W-1:0] match_b,
  input logic              en_a,
  input logic              en_b,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_addr,
  input logic              match_state
);
  logic take;
  assign take = in_valid && in_ready;

  // R9: a stalled output keeps its beat
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr)));

  // R9: no character is taken while the output is stalled
  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8: a marked character equal to neither value closes the filter and is dropped
  a_r8_miss_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_mark && (en_a || en_b) && in_data != match_a && in_data != match_b)
    |=> (!match_state && !out_valid));

  // R7: closed filter drops unmarked data
  a_r7_closed_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_mark && (en_a || en_b) && !match_state) |=> !out_valid);

  // R10: bypass traffic never moves the accept flag
  a_r10_bypass_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !en_a && !en_b) |=> $stable(match_state));

  // R6: an address beat on the output implies the filter is open
  a_r6_addr_open: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_addr) |-> match_state);
endmodule

bind uart_addr_filter uaf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_mark(in_mark), .match_a(match_a), .match_b(match_b),
  .en_a(en_a), .en_b(en_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_addr(out_addr), .match_state(match_state)
);

// File: tb/tb_uart_addr_filter.sv
`timescale 1ns/1ps
module tb_uart_addr_filter;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_mark = 1'b0;
  logic [DW-1:0] in_data = '0, match_a = 8'h21, match_b = 8'h22;
  logic          en_a = 1'b0, en_b = 1'b0, out_ready = 1'b1;
  logic          in_ready, out_valid, out_addr, match_state;
  logic [DW-1:0] out_data;

  always #4 clk = ~clk;  // 125 MHz

  uart_addr_filter #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mark(in_mark), .match_a(match_a), .match_b(match_b),
    .en_a(en_a), .en_b(en_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_addr(out_addr), .match_state(match_state)
  );

  int    n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit    bp_mode = 1'b0;
  bit    cmp_on = 1'b0;

  // Behavioural reference state
  bit          m_valid, m_addr, m_acc;
  bit [DW-1:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_addr = 0; m_acc = 0; m_data = '0;
    end else begin
      bit rdy, anyen, hit, w, adr;
      rdy = !m_valid || out_ready;
      if (in_valid && rdy) begin
        anyen = en_a || en_b;
        hit = (en_a && in_data == match_a) || (en_b && in_data == match_b);
        if (!anyen)       begin w = 1;     adr = 0; end
        else if (in_mark) begin w = hit;   adr = 1; m_acc = hit; end
        else              begin w = m_acc; adr = 0; end
        m_valid = w;
        if (w) begin m_data = in_data; m_addr = adr; end
      end else if (out_ready) begin
        m_valid = 0;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    out_ready <= bp_mode ? 1'($urandom % 2) : 1'b1;
  end

  // Compare every cycle, well after the edge and after out_ready settles
  always @(negedge clk) begin
    #2;
    if (cmp_on) begin
      check(cur_req, "in_ready", int'(in_ready), int'(!m_valid || out_ready));
      check(cur_req, "out_valid", int'(out_valid), int'(m_valid));
      check(cur_req, "match_state", int'(match_state), int'(m_acc));
      if (m_valid) begin
        check(cur_req, "out_data", int'(out_data), int'(m_data));
        check(cur_req, "out_addr", int'(out_addr), int'(m_addr));
      end
    end
  end

  // Offer one character and hold it until taken
  task automatic send(input logic [DW-1:0] d, input logic mk);
    bit taken;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_mark = mk;
    taken = 0;
    while (!taken) begin
      #1;
      taken = in_ready;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic rnd_burst(input int n);
    for (int i = 0; i < n; i++)
      send(8'h20 + 8'($urandom % 4), 1'($urandom % 3 == 0));
  endtask

  task automatic stimulus();
    repeat (3) @(negedge clk);
    #2;
    check("R1", "reset out_valid", int'(out_valid), 0);
    check("R1", "reset match_state", int'(match_state), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R1: filtering on, unmarked before any hit is dropped
    cur_req = "R1"; en_a = 1;
    send(8'h55, 0);
    @(negedge clk); #3;
    check("R1", "no data before hit", int'(out_valid), 0);

    // R3: only en_a, mark equal to match_b must miss
    cur_req = "R3";
    send(8'h22, 1);
    @(negedge clk); #3;
    check("R3", "match_b ignored", int'(match_state), 0);
    send(8'h21, 1); send(8'h40, 0); send(8'h22, 1); send(8'h41, 0);
    rnd_burst(60);

    // R4: only en_b
    cur_req = "R4"; en_a = 0; en_b = 1;
    send(8'h21, 1);
    @(negedge clk); #3;
    check("R4", "match_a ignored", int'(match_state), 0);
    send(8'h22, 1); send(8'h42, 0);
    rnd_burst(60);

    // R5 / R6 / R7 / R8: both enables
    cur_req = "R5"; en_a = 1;
    send(8'h21, 1); send(8'h43, 0); send(8'h22, 1); send(8'h44, 0);
    cur_req = "R8";
    send(8'h23, 1); send(8'h45, 0);
    @(negedge clk); #3;
    check("R8", "miss closes", int'(match_state), 0);
    cur_req = "R6";
    send(8'h22, 1);
    @(negedge clk); #3;
    check("R6", "hit opens", int'(match_state), 1);
    cur_req = "R7";
    rnd_burst(80);

    // R10 / R2: bypass with known state
    cur_req = "R10";
    send(8'h21, 1);
    en_a = 0; en_b = 0;
    send(8'h23, 1); send(8'h46, 0);
    @(negedge clk); #3;
    check("R10", "bypass keeps state", int'(match_state), 1);
    cur_req = "R2";
    rnd_burst(60);

    // R9: back-pressure across all modes
    cur_req = "R9"; bp_mode = 1;
    for (int m = 0; m < 4; m++) begin
      en_a = m[0]; en_b = m[1];
      match_a = 8'h20 + 8'($urandom % 4);
      match_b = 8'h20 + 8'($urandom % 4);
      rnd_burst(200);
    end
    bp_mode = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    bit timeout = 0;
    fork
      stimulus();
      begin repeat (100000) @(posedge clk); timeout = 1; end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule